// File: doc/BRIEF.md
# Synchronised Four-Channel DAC Register Bank

This block holds the output codes and the range selections for four 12-bit digital-to-analog channels and exposes them through a small register window. Software can write this window in bytes or in words. Each channel has a staging register. While synchronous mode is on, writes land only in the staging registers, and a write to a single load address then moves every staged code to the live output buses on the same clock edge. This lets all four converters change together. While synchronous mode is off, a data write reaches its channel's live output on the next clock.

The range selections are packed two bits per channel into one readable byte, and they drive the converters' range pins directly. A one-cycle pulse marks every clock in which at least one live code changed, so that the converters can latch. At reset the bank enters synchronous mode, selects the bipolar range on every channel and drives the midscale code. The converters themselves lie outside the block.

Top module: `sync_dac_bank`

## Requirements
- R1: After reset every live code and every staged code is 0x800, the range byte reads 0xAA, the control register reads 1 (synchronous mode) and the update pulse is low.
- R2: A word write to offset 2n (n = 0..3) stores wr_data[11:0] in channel n's staging register and drops bits 15:12. A read of offset 2n returns the staged code zero-extended to 16 bits.
- R3: A byte write to offset 2n replaces only staged bits 7:0 with wr_data[7:0]. A byte or word write to offset 2n+1 replaces only staged bits 11:8 with wr_data[3:0]. A read of offset 2n+1 returns staged bits 11:8 in rd_data[3:0], with all other bits zero.
- R4: While control bit 0 is 1, data writes leave every live output unchanged.
- R5: Any write to offset 9 copies all four staged codes to the live outputs at that clock edge, whatever the mode and the data value. The new codes are visible from the next cycle.
- R6: While control bit 0 is 0, a data write to a channel shows its new staged code on that channel's live output from the next cycle.
- R7: A write to offset 8 stores wr_data[7:0] as the range byte. Channel n's 2-bit range output is byte bits 2n+1..2n. The new ranges appear on the next cycle in either mode, and a read of offset 8 returns the byte.
- R8: A write to offset 15 sets the mode from wr_data[0] (1 = synchronous, 0 = direct). A read of offset 15 returns that bit in rd_data[0] with all other bits zero.
- R9: upd_pulse is high for exactly the cycles in which at least one live code differs from its value in the previous cycle. A load with nothing to change does not raise it.
- R10: Offsets 10 to 14 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| addr | input | 4 | Register offset |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_data | output | 16 | Combinational read data for addr |
| dac_code | output | 48 | Live codes, channel n in bits 12n+11..12n |
| dac_range | output | 8 | Range selects, channel n in bits 2n+1..2n |
| upd_pulse | output | 1 | High in each cycle that follows a live code change |

## Verification
The embedded properties assume that rst_n is asserted long enough for every register to take its reset value. They also assume that addr, wr_en, wr_word and wr_data are stable around the sampling edge, so that one decoded write enable at most is active per cycle. The bench changes all inputs only on the falling clock edge and never issues more than one access per cycle. Its random phase draws offsets from the full 4-bit space, so unmapped offsets, odd-offset word writes and mode flips mixed with loads all occur while those assumptions still hold.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
   localparam int OFS_RANGE = 8;
   localparam int OFS_LOAD  = 9;
   localparam int OFS_CTRL  = 15;
   localparam int BUS_W     = 16;
   localparam int LANE_W    = 8;

   function automatic int midscale(input int width);
      return 1 << (width - 1);
   endfunction
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
   parameter int NCH = 4,
   parameter int AW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           wr_word,
   input  logic [AW-1:0]  addr,
   output logic [NCH-1:0] lo_we,
   output logic [NCH-1:0] hi_we,
   output logic           hi_from_upper,
   output logic           rng_we,
   output logic           ctl_we,
   output logic           load_all
);
   import dacbank_pkg::*;

   localparam logic [AW-1:0] DATA_END = AW'(2 * NCH);
   localparam logic [AW-1:0] A_RANGE  = AW'(OFS_RANGE);
   localparam logic [AW-1:0] A_LOAD   = AW'(OFS_LOAD);
   localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);

   logic in_data;
   assign in_data       = wr_en && (addr < DATA_END);
   assign hi_from_upper = !addr[0];
   assign rng_we        = wr_en && (addr == A_RANGE);
   assign ctl_we        = wr_en && (addr == A_CTRL);
   assign load_all      = wr_en && (addr == A_LOAD);

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      logic hit;
      assign hit      = in_data && (addr[AW-1:1] == (AW-1)'(c));
      assign lo_we[c] = hit && !addr[0];
      assign hi_we[c] = hit && (addr[0] || wr_word);
   end

   // R10: an idle bus produces no write enable of any kind
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (lo_we == '0) && (hi_we == '0) && !rng_we && !ctl_we && !load_all);
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
   parameter int DW       = 12,
   parameter int RST_CODE = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lo_we,
   input  logic          hi_we,
   input  logic          hi_from_upper,
   input  logic [7:0]    lane_lo,
   input  logic [DW-9:0] lane_hi_a,
   input  logic [DW-9:0] lane_hi_b,
   input  logic          sync_mode,
   input  logic          load_all,
   output logic [DW-1:0] stg_q,
   output logic [DW-1:0] live_q,
   output logic          live_chg
);
   logic [DW-1:0] stg_d;
   logic [DW-1:0] live_d;
   logic          direct_ld;

   always_comb begin
      stg_d = stg_q;
      if (lo_we) stg_d[7:0] = lane_lo;
      if (hi_we) stg_d[DW-1:8] = hi_from_upper ? lane_hi_a : lane_hi_b;
   end

   assign direct_ld = (lo_we || hi_we) && !sync_mode;

   always_comb begin
      if (load_all)       live_d = stg_q;
      else if (direct_ld) live_d = stg_d;
      else                live_d = live_q;
   end

   assign live_chg = (live_d != live_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= DW'(RST_CODE);
         live_q <= DW'(RST_CODE);
      end else begin
         stg_q  <= stg_d;
         live_q <= live_d;
      end
   end

   // R4: synchronous mode without a load keeps the live code
   a_r4_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !load_all) |=> $stable(live_q));
   // R5: a load copies the staged code
   a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load_all |=> (live_q == $past(stg_q)));
   // R6: direct mode makes live follow staging after a data write
   a_r6_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode && (lo_we || hi_we)) |=> (live_q == stg_q));
endmodule

// File: rtl/dacbank_range.sv
module dacbank_range #(
   parameter int         NCH     = 4,
   parameter int         RW      = 2,
   parameter logic [7:0] RST_RNG = 8'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rng_we,
   input  logic [7:0]        wr_byte,
   output logic [7:0]        rng_q,
   output logic [NCH*RW-1:0] rng_out
);
   localparam int USED = NCH * RW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rng_q <= RST_RNG;
      else if (rng_we) rng_q <= wr_byte;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign rng_out[c*RW +: RW] = rng_q[c*RW +: RW];
   end

   if (USED < 8) begin : g_spare
      logic unused_rng_bits;
      assign unused_rng_bits = ^rng_q[7:USED];
   end

   // R7: a range write lands on the next cycle
   a_r7_range_write: assert property (@(posedge clk) disable iff (!rst_n)
      rng_we |=> (rng_q == $past(wr_byte)));
   a_r7_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rng_we |=> $stable(rng_q));
endmodule

// File: rtl/sync_dac_bank.sv
module sync_dac_bank #(
   parameter int         NCH      = 4,
   parameter int         DW       = 12,
   parameter int         RW       = 2,
   parameter int         AW       = 4,
   parameter logic [7:0] RST_RNG  = 8'hAA,
   parameter bit         RST_SYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_word,
   input  logic [AW-1:0]     addr,
   input  logic [15:0]       wr_data,
   output logic [15:0]       rd_data,
   output logic [NCH*DW-1:0] dac_code,
   output logic [NCH*RW-1:0] dac_range,
   output logic              upd_pulse
);
   import dacbank_pkg::*;

   localparam int            RST_CODE = midscale(DW);
   localparam int            HW       = DW - LANE_W;
   localparam logic [AW-1:0] DATA_END = AW'(2 * NCH);
   localparam logic [AW-1:0] A_RANGE  = AW'(OFS_RANGE);
   localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);

   if (DW <= LANE_W || DW > BUS_W) begin : g_bad_dw
      $error("DW must lie in 9..16");
   end
   if (NCH * RW > LANE_W) begin : g_bad_rng
      $error("range fields must fit one byte");
   end
   if (2 * NCH > OFS_RANGE) begin : g_bad_nch
      $error("data offsets would overlap the range register");
   end
   if (AW < 4) begin : g_bad_aw
      $error("address must reach the control offset");
   end

   logic [NCH-1:0] lo_we, hi_we, chg;
   logic           hi_from_upper, rng_we, ctl_we, load_all;
   logic           sync_q, upd_q;
   logic [7:0]     rng_q;
   logic [DW-1:0]  stg  [NCH];
   logic [DW-1:0]  live [NCH];

   dacbank_decode #(.NCH(NCH), .AW(AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .addr(addr),
      .lo_we(lo_we), .hi_we(hi_we), .hi_from_upper(hi_from_upper),
      .rng_we(rng_we), .ctl_we(ctl_we), .load_all(load_all)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacbank_chan #(.DW(DW), .RST_CODE(RST_CODE)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .lo_we(lo_we[c]), .hi_we(hi_we[c]), .hi_from_upper(hi_from_upper),
         .lane_lo(wr_data[7:0]), .lane_hi_a(wr_data[DW-1:8]),
         .lane_hi_b(wr_data[HW-1:0]),
         .sync_mode(sync_q), .load_all(load_all),
         .stg_q(stg[c]), .live_q(live[c]), .live_chg(chg[c])
      );
      assign dac_code[c*DW +: DW] = live[c];
   end

   dacbank_range #(.NCH(NCH), .RW(RW), .RST_RNG(RST_RNG)) u_rng (
      .clk(clk), .rst_n(rst_n), .rng_we(rng_we), .wr_byte(wr_data[7:0]),
      .rng_q(rng_q), .rng_out(dac_range)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= RST_SYNC;
         upd_q  <= 1'b0;
      end else begin
         if (ctl_we) sync_q <= wr_data[0];
         upd_q <= |chg;
      end
   end
   assign upd_pulse = upd_q;

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if ((addr < DATA_END) && (addr[AW-1:1] == (AW-1)'(c))) begin
            if (addr[0]) rd_data = 16'(stg[c][DW-1:8]);
            else         rd_data = 16'(stg[c]);
         end
      end
      if (addr == A_RANGE) rd_data = {8'h00, rng_q};
      if (addr == A_CTRL)  rd_data = {15'h0000, sync_q};
   end

   // R8: the mode bit follows a control write
   a_r8_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (sync_q == $past(wr_data[0])));
   // R9: pulse only with a change, and no change without a pulse
   a_r9_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> (dac_code != $past(dac_code)));
   a_r9_quiet_means_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |-> $stable(dac_code));
   // R2/R3: at most one channel is addressed per cycle
   a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lo_we | hi_we));
endmodule

// File: tb/sync_dac_bank_tb.sv
module sync_dac_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_word = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [47:0] dac_code;
   logic [7:0]  dac_range;
   logic        upd_pulse;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference state
   int m_stg [4];
   int m_live[4];
   int m_rng, m_sync, m_upd;

   always #5 clk = ~clk;

   sync_dac_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .dac_code(dac_code),
      .dac_range(dac_range), .upd_pulse(upd_pulse)
   );

   always @(posedge clk) begin
      int old[4];
      int ch;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_stg[i] = 'h800; m_live[i] = 'h800; end
         m_rng = 'hAA; m_sync = 1; m_upd = 0;
      end else begin
         for (int i = 0; i < 4; i++) old[i] = m_live[i];
         if (wr_en) begin
            if (addr < 8) begin
               ch = addr / 2;
               if (addr % 2 == 0) begin
                  m_stg[ch] = (m_stg[ch] & 'hF00) | (wr_data & 'hFF);
                  if (wr_word) m_stg[ch] = (m_stg[ch] & 'h0FF) | (wr_data & 'hF00);
               end else begin
                  m_stg[ch] = (m_stg[ch] & 'h0FF) | ((wr_data & 'hF) << 8);
               end
               if (m_sync == 0) m_live[ch] = m_stg[ch];
            end else if (addr == 8) m_rng = wr_data & 'hFF;
            else if (addr == 9) begin
               for (int i = 0; i < 4; i++) m_live[i] = m_stg[i];
            end else if (addr == 15) m_sync = wr_data & 1;
         end
         m_upd = 0;
         for (int i = 0; i < 4; i++) if (old[i] != m_live[i]) m_upd = 1;
      end
   end

   function automatic int m_read(int a);
      if (a < 8) return (a % 2 == 0) ? m_stg[a/2] : (m_stg[a/2] >> 8);
      if (a == 8) return m_rng;
      if (a == 15) return m_sync;
      return 0;
   endfunction

   task automatic check_all(string req);
      bit bad = 1'b0;
      tests++;
      for (int i = 0; i < 4; i++) begin
         if (int'(dac_code[i*12 +: 12]) != m_live[i]) begin
            $display("FAIL %s ch%0d code act=%h exp=%h", req, i, dac_code[i*12 +: 12], m_live[i]);
            bad = 1'b1;
         end
         if (int'(dac_range[i*2 +: 2]) != ((m_rng >> (2*i)) & 3)) begin
            $display("FAIL %s ch%0d range act=%0d exp=%0d", req, i, dac_range[i*2 +: 2], (m_rng >> (2*i)) & 3);
            bad = 1'b1;
         end
      end
      if (int'(upd_pulse) != m_upd) begin
         $display("FAIL %s upd_pulse act=%0b exp=%0d", req, upd_pulse, m_upd);
         bad = 1'b1;
      end
      if (int'(rd_data) != m_read(int'(addr))) begin
         $display("FAIL %s rd_data@%0d act=%h exp=%h", req, addr, rd_data, m_read(int'(addr)));
         bad = 1'b1;
      end
      if (bad) fails++;
   endtask

   task automatic op(bit we, bit word, int a, int d, string req);
      @(negedge clk);
      check_all(cur_req);
      cur_req = req;
      wr_en = we; wr_word = word; addr = 4'(a); wr_data = 16'(d);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=timeout exp=completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values, read back control, range and a data offset
      op(0, 0, 15, 0, "R1");
      op(0, 0, 8, 0, "R1");
      op(0, 0, 2, 0, "R1");
      // R2 and R4: word writes in synchronous mode, upper nibble dropped
      op(1, 1, 0, 'hF123, "R4");
      op(1, 1, 2, 'hA456, "R4");
      op(1, 1, 4, 'h0789, "R4");
      op(1, 1, 6, 'h5ABC, "R4");
      for (int a = 0; a < 8; a += 2) op(0, 0, a, 0, "R2");
      // R5 and R9: load moves all four at once, pulse for one cycle
      op(1, 0, 9, 'h0000, "R5");
      op(0, 0, 0, 0, "R9");
      // R9: a second load with nothing to change gives no pulse
      op(1, 1, 9, 'hFFFF, "R9");
      op(0, 0, 1, 0, "R9");
      // R3: byte lanes on even and odd offsets, word write to an odd offset
      op(1, 0, 0, 'h33EE, "R3");
      op(1, 0, 3, 'hFFF5, "R3");
      op(1, 1, 5, 'h00AC, "R3");
      for (int a = 0; a < 8; a++) op(0, 0, a, 0, "R3");
      // R7: range writes take effect in synchronous mode without a load
      op(1, 0, 8, 'h1B, "R7");
      op(1, 1, 8, 'hFFE4, "R7");
      op(0, 0, 8, 0, "R7");
      // R8: leave synchronous mode, read the control register
      op(1, 1, 15, 'hFFFE, "R8");
      op(0, 0, 15, 0, "R8");
      // R6: direct mode writes reach the outputs next cycle
      op(1, 1, 6, 'h0FFF, "R6");
      op(1, 0, 2, 'h0011, "R6");
      op(1, 0, 5, 'h0003, "R6");
      op(0, 0, 6, 0, "R6");
      // R10: unmapped offsets read zero and write nothing
      for (int a = 10; a < 15; a++) op(1, 1, a, 'hFFFF, "R10");
      for (int a = 10; a < 15; a++) op(0, 0, a, 0, "R10");
      // R8: back to synchronous mode, then a stage and load
      op(1, 0, 15, 'h01, "R8");
      op(1, 1, 0, 'h0000, "R4");
      op(1, 1, 9, 0, "R5");
      // mixed traffic across every offset
      for (int i = 0; i < 600; i++)
         op($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)), "R9");
      op(0, 0, 0, 0, "R2");
      op(0, 0, 0, 0, "R2");
      summary();
   end
endmodule